// File: doc/BRIEF.md
# PLL Configuration Register Bank with Bit-Masked Writes

This block holds the control settings for one phase-locked loop and for the selector that picks the clock source behind it. Four 16-bit configuration words carry the output divider, the reference divider, the feedback multiplier, the loop bandwidth trim and three control bits: reset, power-down and bypass. A fifth word holds a 2-bit source-select field. The field chooses between the slow reference, the PLL output and a low-frequency sleep source.

Every word is written over a simple word-addressed bus, and each write is bit-masked. Write data is 32 bits wide. Its upper 16 bits act as a per-bit write enable for its lower 16 bits. Software can therefore change one field, such as the power-down bit, without reading the word first. Reads return the stored 16 bits with zeros above them. Every field output is a flip-flop output.

Top module: `pll_cfg_bank`

## Requirements
- R1: After reset, configuration word 3 reads 0x0000_0003, every other word reads zero, pll_pd and pll_byp are 1, pll_rst is 0 and mode_sel is 0.
- R2: On a write, stored bit i (0 to 15) takes wdata[i] only when wdata[i+16] is 1. Every other stored bit keeps its value.
- R3: Configuration word n (n = 0..3) is at byte address 4*n, and the mode word is at byte address MODE_OFFSET (default 0x40). Any other address, including ones whose two low bits are not zero, is unmapped.
- R4: out_div is word 0 bits [3:0] (the output divider minus one), and ref_div is word 0 bits [13:8] (the reference divider minus one).
- R5: fb_mult is word 1 bits [12:0] (the feedback multiplier minus one).
- R6: bw_adj is word 2 bits [11:0].
- R7: In word 3, bit 5 drives pll_rst, bit 1 drives pll_pd and bit 0 drives pll_byp.
- R8: mode_sel is bits [MODE_SHIFT+1:MODE_SHIFT] of the mode word (default MODE_SHIFT = 8). Its encodings are 0 for the slow reference, 1 for the PLL output and 2 for the sleep source.
- R9: rdata is loaded on the clock edge where rd_en is high and holds its value while rd_en is low. It carries the stored 16 bits with bits [31:16] zero, and it is zero when the address is unmapped.
- R10: A write to an unmapped address changes no stored bit and no output.
- R11: A write takes effect on the field outputs at the clock edge that samples wr_en.
- R12: When a read and a write hit the same word in the same cycle, rdata returns the value from before the write.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data; [31:16] is the per-bit mask for [15:0] |
| rdata | output | 32 | Registered read data |
| out_div | output | 4 | Output divider minus one |
| ref_div | output | 6 | Reference divider minus one |
| fb_mult | output | 13 | Feedback multiplier minus one |
| bw_adj | output | 12 | Bandwidth adjust |
| pll_rst | output | 1 | PLL reset control |
| pll_pd | output | 1 | PLL power-down control |
| pll_byp | output | 1 | PLL bypass control |
| mode_sel | output | 2 | Clock source select |

## Verification
The field outputs are flip-flop outputs, so a wrongly merged mask, a bad address decode or a wrong reset value shows on the field outputs one edge after the write or the reset. The registered read port shows the same fault one edge after a read of that word. A write that lands in the wrong word, or that goes to an unmapped address, is caught by a read of every word that was not meant to change. These reads also catch stored bits that no field output shows, because they return all 16 bits of each word.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;

  localparam int BUS_W     = 32;
  localparam int HALF_W    = 16;
  localparam int NUM_CFG   = 4;
  localparam int NUM_SLOTS = NUM_CFG + 1;
  localparam int MODE_SLOT = NUM_CFG;
  localparam int CTRL_SLOT = 3;

  // field layout inside the configuration words
  localparam int OD_LSB   = 0;
  localparam int OD_W     = 4;
  localparam int RD_LSB   = 8;
  localparam int RD_W     = 6;
  localparam int FB_LSB   = 0;
  localparam int FB_W     = 13;
  localparam int BW_LSB   = 0;
  localparam int BW_W     = 12;
  localparam int RST_BIT  = 5;
  localparam int PD_BIT   = 1;
  localparam int BYP_BIT  = 0;
  localparam int MODE_W   = 2;

  localparam logic [HALF_W-1:0] CTRL_RST_VAL =
    HALF_W'((1 << PD_BIT) | (1 << BYP_BIT));

  typedef enum logic [MODE_W-1:0] {
    SRC_SLOW  = 2'd0,
    SRC_PLL   = 2'd1,
    SRC_DEEP  = 2'd2,
    SRC_RSVD  = 2'd3
  } src_sel_e;

  typedef logic [HALF_W-1:0] half_t;

  function automatic half_t slot_reset(input int idx);
    return (idx == CTRL_SLOT) ? CTRL_RST_VAL : '0;
  endfunction

  function automatic half_t masked_merge(input half_t old_v,
                                         input logic [BUS_W-1:0] wd);
    half_t en;
    en = wd[BUS_W-1:HALF_W];
    return (old_v & ~en) | (wd[HALF_W-1:0] & en);
  endfunction

endpackage

// File: rtl/pllreg_decode.sv
module pllreg_decode
  import pllreg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int MODE_OFFSET = 'h40
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_SLOTS-1:0] hit
);

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      if (g < NUM_CFG) begin : g_cfg
        assign hit[g] = (addr == ADDR_W'(4 * g));
      end else begin : g_mode
        assign hit[g] = (addr == ADDR_W'(MODE_OFFSET));
      end
    end
  endgenerate

endmodule

// File: rtl/pllreg_mword.sv
module pllreg_mword
  import pllreg_pkg::*;
#(
  parameter logic [HALF_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output logic [HALF_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (we) begin
      q <= masked_merge(q, wdata);
    end
  end

endmodule

// File: rtl/pllreg_rdport.sv
module pllreg_rdport
  import pllreg_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  logic [NUM_SLOTS-1:0]              hit,
  input  logic [NUM_SLOTS-1:0][HALF_W-1:0]  words,
  output logic [BUS_W-1:0]                  rdata
);

  half_t sel_v;

  always_comb begin
    sel_v = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      sel_v = sel_v | (words[i] & {HALF_W{hit[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= {{(BUS_W-HALF_W){1'b0}}, sel_v};
    end
  end

endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
  import pllreg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int MODE_OFFSET = 'h40,
  parameter int MODE_SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic [OD_W-1:0]   out_div,
  output logic [RD_W-1:0]   ref_div,
  output logic [FB_W-1:0]   fb_mult,
  output logic [BW_W-1:0]   bw_adj,
  output logic              pll_rst,
  output logic              pll_pd,
  output logic              pll_byp,
  output logic [MODE_W-1:0] mode_sel
);

  logic [NUM_SLOTS-1:0]             hit;
  logic [NUM_SLOTS-1:0][HALF_W-1:0] words;

  pllreg_decode #(
    .ADDR_W      (ADDR_W),
    .MODE_OFFSET (MODE_OFFSET)
  ) u_dec (
    .addr (addr),
    .hit  (hit)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_word
      pllreg_mword #(
        .RST_VAL (slot_reset(g))
      ) u_word (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en & hit[g]),
        .wdata (wdata),
        .q     (words[g])
      );
    end
  endgenerate

  pllreg_rdport u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .hit   (hit),
    .words (words),
    .rdata (rdata)
  );

  // field taps: every output is a flip-flop bit
  assign out_div  = words[0][OD_LSB +: OD_W];
  assign ref_div  = words[0][RD_LSB +: RD_W];
  assign fb_mult  = words[1][FB_LSB +: FB_W];
  assign bw_adj   = words[2][BW_LSB +: BW_W];
  assign pll_rst  = words[CTRL_SLOT][RST_BIT];
  assign pll_pd   = words[CTRL_SLOT][PD_BIT];
  assign pll_byp  = words[CTRL_SLOT][BYP_BIT];
  assign mode_sel = words[MODE_SLOT][MODE_SHIFT +: MODE_W];

endmodule

// File: rtl/pllreg_chk.sv
module pllreg_chk
  import pllreg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int MODE_OFFSET = 'h40,
  parameter int MODE_SHIFT  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic [OD_W-1:0]   out_div,
  input logic [RD_W-1:0]   ref_div,
  input logic [FB_W-1:0]   fb_mult,
  input logic [BW_W-1:0]   bw_adj,
  input logic              pll_rst,
  input logic              pll_pd,
  input logic              pll_byp,
  input logic [MODE_W-1:0] mode_sel
);

  logic mapped;
  assign mapped = (addr == ADDR_W'(0)) || (addr == ADDR_W'(4)) ||
                  (addr == ADDR_W'(8)) || (addr == ADDR_W'(12)) ||
                  (addr == ADDR_W'(MODE_OFFSET));

  assert_rdata_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rdata[BUS_W-1:HALF_W] == '0);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode_sel) && $stable(fb_mult) && $stable(out_div) &&
               $stable(ref_div) && $stable(bw_adj) && $stable(pll_pd));

  assert_masked_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(12) && !wdata[HALF_W + BYP_BIT]) |=> $stable(pll_byp));

  assert_mode_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(MODE_OFFSET) &&
     wdata[HALF_W + MODE_SHIFT +: MODE_W] == 2'b11)
    |=> mode_sel == $past(wdata[MODE_SHIFT +: MODE_W]));

  assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped) |=> $stable(out_div) && $stable(ref_div) &&
      $stable(fb_mult) && $stable(bw_adj) && $stable(pll_rst) &&
      $stable(pll_pd) && $stable(pll_byp) && $stable(mode_sel));

  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);

endmodule

bind pll_cfg_bank pllreg_chk #(
  .ADDR_W      (ADDR_W),
  .MODE_OFFSET (MODE_OFFSET),
  .MODE_SHIFT  (MODE_SHIFT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .out_div  (out_div),
  .ref_div  (ref_div),
  .fb_mult  (fb_mult),
  .bw_adj   (bw_adj),
  .pll_rst  (pll_rst),
  .pll_pd   (pll_pd),
  .pll_byp  (pll_byp),
  .mode_sel (mode_sel)
);

// File: tb/sim_pll_cfg_bank.sv
module sim_pll_cfg_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  out_div;
  logic [5:0]  ref_div;
  logic [12:0] fb_mult;
  logic [11:0] bw_adj;
  logic        pll_rst, pll_pd, pll_byp;
  logic [1:0]  mode_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_cfg_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .out_div(out_div), .ref_div(ref_div),
    .fb_mult(fb_mult), .bw_adj(bw_adj), .pll_rst(pll_rst), .pll_pd(pll_pd),
    .pll_byp(pll_byp), .mode_sel(mode_sel)
  );

  // {addr[7:0], wdata[31:0], expected read-back[15:0]}, applied in order
  localparam int NV = 11;
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 32'h3F0F_2A05, 16'h2A05},  // R4 fields fully enabled
    {8'h00, 32'h000F_0003, 16'h2A03},  // R2 only low nibble
    {8'h04, 32'h1FFF_1234, 16'h1234},  // R5
    {8'h04, 32'hFFFF_0000, 16'h0000},  // R2 clear all
    {8'h08, 32'h0FFF_0ABC, 16'h0ABC},  // R6
    {8'h08, 32'h00F0_FFFF, 16'h0AFC},  // R2 partial
    {8'h0C, 32'h0020_0020, 16'h0023},  // R7 set reset only
    {8'h0C, 32'h0003_0000, 16'h0020},  // R7 clear pd and bypass
    {8'h40, 32'h0300_0100, 16'h0100},  // R8 select pll output
    {8'h40, 32'h8000_FFFF, 16'h8100},  // R2 one bit of mode word
    {8'h0C, 32'h0000_FFFF, 16'h0020}   // R2 empty mask
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pd", {31'b0, pll_pd}, 32'd1);
    check("R1 byp", {31'b0, pll_byp}, 32'd1);
    check("R1 rst", {31'b0, pll_rst}, 32'd0);
    check("R1 mode", {30'b0, mode_sel}, 32'd0);
    do_read(8'h00, rv); check("R1 word0", rv, 32'h0);
    do_read(8'h04, rv); check("R1 word1", rv, 32'h0);
    do_read(8'h08, rv); check("R1 word2", rv, 32'h0);
    do_read(8'h0C, rv); check("R1 word3", rv, 32'h3);
    do_read(8'h40, rv); check("R1 mode word", rv, 32'h0);

    // table walk: R2 R3 masked writes with read-back
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][55:48], VEC[i][47:16]);
      do_read(VEC[i][55:48], rv);
      check("R2 R3 table", rv, {16'h0, VEC[i][15:0]});
    end

    // field outputs after the table
    check("R4 out_div", {28'b0, out_div}, 32'h3);
    check("R4 ref_div", {26'b0, ref_div}, 32'h2A);
    check("R5 fb_mult", {19'b0, fb_mult}, 32'h0);
    check("R6 bw_adj", {20'b0, bw_adj}, 32'hAFC);
    check("R7 ctrl bits", {29'b0, pll_rst, pll_pd, pll_byp}, 32'b100);
    check("R8 mode pll", {30'b0, mode_sel}, 32'd1);

    // R11: output visible at the negedge right after the write edge
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h04; wdata = 32'h1FFF_1FFF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 R5 fb_mult max", {19'b0, fb_mult}, 32'h1FFF);

    // R8 deep sleep source
    do_write(8'h40, 32'h0300_0200);
    check("R8 mode deep", {30'b0, mode_sel}, 32'd2);

    // R10 unmapped and misaligned writes ignored
    do_write(8'h10, 32'hFFFF_FFFF);
    do_write(8'h01, 32'hFFFF_0000);
    do_write(8'h41, 32'hFFFF_0000);
    do_read(8'h00, rv); check("R10 word0", rv, 32'h2A03);
    do_read(8'h04, rv); check("R10 word1", rv, 32'h1FFF);
    do_read(8'h08, rv); check("R10 word2", rv, 32'h0AFC);
    do_read(8'h0C, rv); check("R10 word3", rv, 32'h0020);
    do_read(8'h40, rv); check("R10 mode word", rv, 32'h8200);
    do_read(8'h10, rv); check("R9 unmapped read", rv, 32'h0);

    // R12 read and write together return the old value
    do_write(8'h08, 32'hFFFF_0000);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h08; wdata = 32'h0001_0001;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R12 old value", rdata, 32'h0);
    // R9 rdata holds while rd_en is low
    repeat (2) @(negedge clk);
    check("R9 hold", rdata, 32'h0);
    do_read(8'h08, rv); check("R12 new value", rv, 32'h1);

    // R1 reset again restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 re-reset ctrl", {29'b0, pll_rst, pll_pd, pll_byp}, 32'b011);
    check("R1 re-reset fb", {19'b0, fb_mult}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule